// File: doc/BRIEF.md
# Delta-Modulation Sample Playback Channel

This block plays back a one-bit delta-encoded sample stored in memory and turns it into a 7-bit output level. Software sets the channel up through four write-only byte registers: a control register, a direct level load, a sample start address and a sample length. A separate enable write starts or stops playback. While playing, the channel fetches sample bytes one at a time over a simple request/acknowledge port, holds one byte in a buffer, and shifts it out least significant bit first. Each bit moves the level up or down by two.

A rate timer paces the output. It is decremented by two on every audio step strobe and reloads from a fixed sixteen-entry period table. When a sample ends, the channel either loops back to its start or, if enabled, raises a sticky interrupt flag. When the buffer runs dry at the start of a new eight-bit output cycle, the channel goes silent and holds its level.

Top module: `delta_playback`

## Requirements
- R1: Control write (select 0) decodes bit 7 as interrupt enable, bit 6 as loop and bits 3:0 as rate index; bits 5:4 have no effect. The rate index picks a period of 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72 or 54 (index 0 to 15). The timer drops by 2 per step strobe, so the output unit is clocked once every period/2 steps.
- R2: A write to select 1 sets the level to bits 6:0 of the written byte.
- R3: A write of v to select 2 sets the sample start to 0xC000 + 64·v. A write of n to select 3 sets the sample length to 16·n + 1 bytes.
- R4: On each output clock that is not silent, bit 0 of the shift register steps the level. A 1 adds 2 if the level is ≤ 125, a 0 subtracts 2 if the level is ≥ 2, and otherwise the level is held. Bits are used LSB first.
- R5: Output cycles are eight output clocks long. A cycle that starts with an empty buffer is silent, and the level stays unchanged for all of it.
- R6: While the buffer is empty and bytes remain, mem_req is high with mem_addr at the current address. Each acknowledge fills the buffer, decrements the bytes remaining and advances the address, wrapping from 0xFFFF to 0x8000.
- R7: An enable write of 1 reloads the address and length only when no bytes remain. An enable write of 0 sets the bytes remaining to zero, so no further fetch is made.
- R8: With loop set, the fetch of the last byte reloads the start address and length, and no interrupt is raised.
- R9: With interrupt enable set and loop clear, the fetch of the last byte sets irq. irq stays set until a control write with bit 7 clear.
- R10: After reset the level is 0, irq is 0, mem_req is 0 and the timer holds the period for rate index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 level load, 2 start, 3 length |
| reg_wdata | input | 8 | Register write data |
| en_wr | input | 1 | Enable write strobe |
| en_val | input | 1 | Enable value written |
| apu_step | input | 1 | Audio step strobe, one per timer decrement |
| mem_req | output | 1 | Sample byte fetch request |
| mem_addr | output | 16 | Fetch address |
| mem_ack | input | 1 | Fetch acknowledge; mem_rdata valid |
| mem_rdata | input | 8 | Fetched sample byte |
| level | output | 7 | Output level |
| irq | output | 1 | Sticky end-of-sample interrupt flag |

## Verification
The bench builds the block with its default parameters: a 16-bit address, a 12-bit length counter, a 7-bit level and a 9-bit timer. The step strobe is held high, so one period/2 window takes that many clocks. At the fastest rates a 65-byte sample fits easily within the run, which brings the 0xFFFF to 0x8000 address wrap and a full length count within reach. Short one-byte samples expose the clamps at both ends of the level range, the loop reload, the sticky interrupt, and enable writes made while bytes are still pending.

// File: rtl/delta_pkg.sv
package delta_pkg;

  localparam int ADDR_W = 16;
  localparam int LEN_W  = 12;
  localparam int LVL_W  = 7;
  localparam int TMR_W  = 9;
  localparam int RATE_W = 4;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_BASE = 2'd2,
    SEL_SIZE = 2'd3
  } reg_sel_e;

  // Output-clock period, in CPU cycles, for each rate index.
  function automatic int rate_period(input int idx);
    case (idx)
      0:  return 428;
      1:  return 380;
      2:  return 340;
      3:  return 320;
      4:  return 286;
      5:  return 254;
      6:  return 226;
      7:  return 214;
      8:  return 190;
      9:  return 160;
      10: return 142;
      11: return 128;
      12: return 106;
      13: return 84;
      14: return 72;
      default: return 54;
    endcase
  endfunction

endpackage

// File: rtl/delta_regs.sv
module delta_regs
  import delta_pkg::*;
#(
  parameter int ADDR_BITS = delta_pkg::ADDR_W,
  parameter int LEN_BITS  = delta_pkg::LEN_W,
  parameter int LVL_BITS  = delta_pkg::LVL_W,
  parameter int RATE_BITS = delta_pkg::RATE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr,
  input  logic [1:0]           sel,
  input  logic [7:0]           wdata,
  output logic                 irq_en,
  output logic                 loop_en,
  output logic [RATE_BITS-1:0] rate_idx,
  output logic [ADDR_BITS-1:0] start_addr,
  output logic [LEN_BITS-1:0]  start_len,
  output logic                 load_we,
  output logic [LVL_BITS-1:0]  load_val,
  output logic                 irq_clr
);
  localparam int ADDR_SHIFT = 6;
  localparam int LEN_SHIFT  = 4;
  localparam int TOP_BITS   = ADDR_BITS - 8 - ADDR_SHIFT;

  logic [7:0] base_q;
  logic [7:0] size_q;
  logic       ctrl_wr;
  logic       unused_bits;

  assign ctrl_wr     = wr && (reg_sel_e'(sel) == SEL_CTRL);
  assign load_we     = wr && (reg_sel_e'(sel) == SEL_LOAD);
  assign load_val    = wdata[LVL_BITS-1:0];
  assign irq_clr     = ctrl_wr && !wdata[7];
  assign unused_bits = ^wdata[5:4];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_en   <= 1'b0;
      loop_en  <= 1'b0;
      rate_idx <= '0;
      base_q   <= '0;
      size_q   <= '0;
    end else if (wr) begin
      case (reg_sel_e'(sel))
        SEL_CTRL: begin
          irq_en   <= wdata[7];
          loop_en  <= wdata[6];
          rate_idx <= wdata[RATE_BITS-1:0];
        end
        SEL_BASE: base_q <= wdata;
        SEL_SIZE: size_q <= wdata;
        default: ;
      endcase
    end
  end

  // Start = top bits set, value above a 64-byte granule; length = 16n + 1.
  assign start_addr = {{TOP_BITS{1'b1}}, base_q, {ADDR_SHIFT{1'b0}}};
  assign start_len  = {size_q, {(LEN_SHIFT-1){1'b0}}, 1'b1};

  assert_ctrl_decode_R1: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr |=> (irq_en == $past(wdata[7])) && (loop_en == $past(wdata[6])));

endmodule

// File: rtl/delta_fetch.sv
module delta_fetch #(
  parameter int ADDR_BITS = delta_pkg::ADDR_W,
  parameter int LEN_BITS  = delta_pkg::LEN_W,
  parameter int BYTE_BITS = delta_pkg::BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_wr,
  input  logic                 en_val,
  input  logic [ADDR_BITS-1:0] start_addr,
  input  logic [LEN_BITS-1:0]  start_len,
  input  logic                 loop_en,
  input  logic                 irq_en,
  input  logic                 irq_clr,
  input  logic                 take,
  output logic                 mem_req,
  output logic [ADDR_BITS-1:0] mem_addr,
  input  logic                 mem_ack,
  input  logic [BYTE_BITS-1:0] mem_rdata,
  output logic                 buf_full,
  output logic [BYTE_BITS-1:0] buf_data,
  output logic                 irq_flag
);
  localparam logic [ADDR_BITS-1:0] WRAP_ADDR = {1'b1, {(ADDR_BITS-1){1'b0}}};
  localparam logic [ADDR_BITS-1:0] LAST_ADDR = '1;

  logic [ADDR_BITS-1:0] cur_addr;
  logic [ADDR_BITS-1:0] next_addr;
  logic [LEN_BITS-1:0]  bytes_left;
  logic                 fetch;
  logic                 last_byte;

  assign mem_req   = !buf_full && (bytes_left != '0);
  assign mem_addr  = cur_addr;
  assign fetch     = mem_req && mem_ack;
  assign last_byte = (bytes_left == LEN_BITS'(1));
  assign next_addr = (cur_addr == LAST_ADDR) ? WRAP_ADDR : cur_addr + ADDR_BITS'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_full <= 1'b0;
      buf_data <= '0;
    end else if (fetch) begin
      buf_full <= 1'b1;
      buf_data <= mem_rdata;
    end else if (take) begin
      buf_full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr   <= '0;
      bytes_left <= '0;
    end else begin
      if (fetch) begin
        if (last_byte && loop_en) begin
          cur_addr   <= start_addr;
          bytes_left <= start_len;
        end else begin
          cur_addr   <= next_addr;
          bytes_left <= bytes_left - LEN_BITS'(1);
        end
      end
      if (en_wr) begin
        if (!en_val) begin
          bytes_left <= '0;
        end else if (bytes_left == '0) begin
          cur_addr   <= start_addr;
          bytes_left <= start_len;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq_flag <= 1'b0;
    else if (irq_clr)
      irq_flag <= 1'b0;
    else if (fetch && last_byte && !loop_en && irq_en)
      irq_flag <= 1'b1;
  end

  assert_fetch_fills_R6: assert property (@(posedge clk) disable iff (rst)
    fetch |=> buf_full && (buf_data == $past(mem_rdata)));

  assert_count_down_R6: assert property (@(posedge clk) disable iff (rst)
    fetch && !en_wr && !last_byte |=> bytes_left == $past(bytes_left) - LEN_BITS'(1));

  assert_addr_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    fetch && !en_wr && !last_byte && (cur_addr == LAST_ADDR) |=> cur_addr == WRAP_ADDR);

  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (rst)
    en_wr && !en_val |=> bytes_left == '0);

  assert_loop_reload_R8: assert property (@(posedge clk) disable iff (rst)
    fetch && last_byte && loop_en && !en_wr |=> (bytes_left == $past(start_len)) && !$rose(irq_flag));

  assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    irq_flag && !irq_clr |=> irq_flag);

endmodule

// File: rtl/delta_output.sv
module delta_output #(
  parameter int LVL_BITS  = delta_pkg::LVL_W,
  parameter int TMR_BITS  = delta_pkg::TMR_W,
  parameter int RATE_BITS = delta_pkg::RATE_W,
  parameter int BYTE_BITS = delta_pkg::BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic [RATE_BITS-1:0] rate_idx,
  input  logic                 buf_full,
  input  logic [BYTE_BITS-1:0] buf_data,
  input  logic                 load_we,
  input  logic [LVL_BITS-1:0]  load_val,
  output logic                 take,
  output logic [LVL_BITS-1:0]  level
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [LVL_BITS-1:0] STEP    = LVL_BITS'(2);
  localparam logic [LVL_BITS-1:0] UP_MAX  = LVL_BITS'((1 << LVL_BITS) - 3);
  localparam logic [CNT_W-1:0]    NBITS   = CNT_W'(BYTE_BITS);
  localparam logic [TMR_BITS-1:0] DEC     = TMR_BITS'(2);
  localparam logic [TMR_BITS-1:0] RST_PER = TMR_BITS'(delta_pkg::rate_period(0));

  logic [TMR_BITS-1:0]  timer;
  logic [TMR_BITS-1:0]  reload;
  logic [BYTE_BITS-1:0] shifter;
  logic [CNT_W-1:0]     bits_left;
  logic                 silent;
  logic [LVL_BITS-1:0]  level_q;
  logic [LVL_BITS-1:0]  level_nx;
  logic                 out_clk;
  logic                 cycle_end;

  assign reload    = TMR_BITS'(delta_pkg::rate_period(int'(rate_idx)));
  assign out_clk   = step && (timer <= DEC);
  assign cycle_end = (bits_left <= CNT_W'(1));
  assign take      = out_clk && cycle_end && buf_full;
  assign level     = level_q;

  always_comb begin
    level_nx = level_q;
    if (!silent) begin
      if (shifter[0]) begin
        if (level_q <= UP_MAX) level_nx = level_q + STEP;
      end else begin
        if (level_q >= STEP) level_nx = level_q - STEP;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      timer <= RST_PER;
    end else if (step) begin
      timer <= out_clk ? reload : timer - DEC;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shifter   <= '0;
      bits_left <= '0;
      silent    <= 1'b1;
    end else if (out_clk) begin
      if (cycle_end) begin
        bits_left <= NBITS;
        if (buf_full) begin
          shifter <= buf_data;
          silent  <= 1'b0;
        end else begin
          shifter <= shifter >> 1;
          silent  <= 1'b1;
        end
      end else begin
        shifter   <= shifter >> 1;
        bits_left <= bits_left - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      level_q <= '0;
    else if (load_we)
      level_q <= load_val;
    else if (out_clk)
      level_q <= level_nx;
  end

  assert_timer_live_R1: assert property (@(posedge clk) disable iff (rst)
    timer != '0);

  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load_we |=> level_q == $past(load_val));

  assert_level_step_R4: assert property (@(posedge clk) disable iff (rst)
    !load_we |=> (level_q == $past(level_q)) || (level_q == $past(level_q) + STEP)
                 || (level_q + STEP == $past(level_q)));

  assert_silent_hold_R5: assert property (@(posedge clk) disable iff (rst)
    silent && !load_we |=> level_q == $past(level_q));

endmodule

// File: rtl/delta_playback.sv
module delta_playback
  import delta_pkg::*;
#(
  parameter int ADDR_BITS = delta_pkg::ADDR_W,
  parameter int LEN_BITS  = delta_pkg::LEN_W,
  parameter int LVL_BITS  = delta_pkg::LVL_W,
  parameter int TMR_BITS  = delta_pkg::TMR_W,
  parameter int RATE_BITS = delta_pkg::RATE_W,
  parameter int BYTE_BITS = delta_pkg::BYTE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_sel,
  input  logic [7:0]           reg_wdata,
  input  logic                 en_wr,
  input  logic                 en_val,
  input  logic                 apu_step,
  output logic                 mem_req,
  output logic [ADDR_BITS-1:0] mem_addr,
  input  logic                 mem_ack,
  input  logic [BYTE_BITS-1:0] mem_rdata,
  output logic [LVL_BITS-1:0]  level,
  output logic                 irq
);
  logic                 irq_en;
  logic                 loop_en;
  logic [RATE_BITS-1:0] rate_idx;
  logic [ADDR_BITS-1:0] start_addr;
  logic [LEN_BITS-1:0]  start_len;
  logic                 load_we;
  logic [LVL_BITS-1:0]  load_val;
  logic                 irq_clr;
  logic                 take;
  logic                 buf_full;
  logic [BYTE_BITS-1:0] buf_data;

  delta_regs #(
    .ADDR_BITS(ADDR_BITS), .LEN_BITS(LEN_BITS),
    .LVL_BITS(LVL_BITS), .RATE_BITS(RATE_BITS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .irq_en(irq_en), .loop_en(loop_en), .rate_idx(rate_idx),
    .start_addr(start_addr), .start_len(start_len),
    .load_we(load_we), .load_val(load_val), .irq_clr(irq_clr)
  );

  delta_fetch #(
    .ADDR_BITS(ADDR_BITS), .LEN_BITS(LEN_BITS), .BYTE_BITS(BYTE_BITS)
  ) u_fetch (
    .clk(clk), .rst(rst), .en_wr(en_wr), .en_val(en_val),
    .start_addr(start_addr), .start_len(start_len),
    .loop_en(loop_en), .irq_en(irq_en), .irq_clr(irq_clr), .take(take),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .buf_full(buf_full), .buf_data(buf_data),
    .irq_flag(irq)
  );

  delta_output #(
    .LVL_BITS(LVL_BITS), .TMR_BITS(TMR_BITS),
    .RATE_BITS(RATE_BITS), .BYTE_BITS(BYTE_BITS)
  ) u_out (
    .clk(clk), .rst(rst), .step(apu_step), .rate_idx(rate_idx),
    .buf_full(buf_full), .buf_data(buf_data),
    .load_we(load_we), .load_val(load_val),
    .take(take), .level(level)
  );

  assert_reset_quiet_R10: assert property (@(posedge clk)
    $fell(rst) |-> (level == '0) && !irq && !mem_req);

endmodule

// File: tb/delta_playback_test.sv
module delta_playback_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic        en_wr = 1'b0;
  logic        en_val = 1'b0;
  logic        apu_step = 1'b1;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = 8'd0;
  logic [6:0]  level;
  logic        irq;

  int          n_tests = 0;
  int          n_fail = 0;
  logic [7:0]  mem_byte = 8'd0;
  int          fetch_cnt = 0;
  logic [15:0] fetch_addr [0:255];
  int          chg_n;
  int          chg_val [0:63];
  int          chg_t [0:63];

  always #4 clk = ~clk;

  delta_playback uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .en_wr(en_wr), .en_val(en_val), .apu_step(apu_step),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .level(level), .irq(irq)
  );

  // Memory model: answer each request one clock later and log the address.
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        if (fetch_cnt < 256) fetch_addr[fetch_cnt] = mem_addr;
        fetch_cnt = fetch_cnt + 1;
        mem_rdata = mem_byte;
        mem_ack = 1'b1;
      end else begin
        mem_ack = 1'b0;
      end
    end
  end

  function automatic int tb_period(input int idx);
    case (idx)
      0: return 428;   1: return 380;   2: return 340;   3: return 320;
      4: return 286;   5: return 254;   6: return 226;   7: return 214;
      8: return 190;   9: return 160;  10: return 142;  11: return 128;
      12: return 106; 13: return 84;   14: return 72;   default: return 54;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    fetch_cnt = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic en(input logic v);
    @(negedge clk);
    en_wr = 1'b1; en_val = v;
    @(negedge clk);
    en_wr = 1'b0;
  endtask

  task automatic watch(input int n);
    logic [6:0] prev;
    prev = level;
    chg_n = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      if (level != prev) begin
        if (chg_n < 64) begin
          chg_val[chg_n] = level;
          chg_t[chg_n] = c;
        end
        chg_n++;
        prev = level;
      end
    end
  endtask

  task automatic wait_fetches(input int n);
    for (int c = 0; c < 20000 && fetch_cnt < n; c++) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(level == 7'd0, "R10 level", level, 0);
    chk(irq == 1'b0, "R10 irq", irq, 0);
    chk(mem_req == 1'b0, "R10 mem_req", mem_req, 0);
  endtask

  task automatic t_direct();
    do_reset();
    wr(2'd1, 8'hFF);
    chk(level == 7'h7F, "R2 load 0xFF", level, 'h7F);
    wr(2'd1, 8'h80);
    chk(level == 7'h00, "R2 load 0x80", level, 0);
    wr(2'd1, 8'h2A);
    chk(level == 7'h2A, "R2 load 0x2A", level, 'h2A);
  endtask

  // Play one byte (length 1) and compare the level trajectory with a model.
  task automatic t_play(input string req, input int lvl0, input logic [7:0] pat,
                        input logic [7:0] ctrl, input bit check_gap);
    int lv;
    int exp_v[8];
    int ne;
    int gap;
    gap = tb_period(int'(ctrl[3:0])) / 2;
    do_reset();
    wr(2'd0, ctrl);
    wr(2'd1, 8'(lvl0));
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h00);
    mem_byte = pat;
    en(1'b1);
    watch(300 + 10 * gap);
    lv = lvl0; ne = 0;
    for (int i = 0; i < 8; i++) begin
      if (pat[i] && lv <= 125) begin lv += 2; exp_v[ne] = lv; ne++; end
      else if (!pat[i] && lv >= 2) begin lv -= 2; exp_v[ne] = lv; ne++; end
    end
    chk(chg_n == ne, {req, " R5 change count"}, chg_n, ne);
    for (int i = 0; i < ne && i < chg_n; i++)
      chk(chg_val[i] == exp_v[i], {req, " R4 step value"}, chg_val[i], exp_v[i]);
    chk(int'(level) == lv, {req, " R4 final level"}, level, lv);
    chk(fetch_cnt == 1, {req, " R3 one-byte length"}, fetch_cnt, 1);
    if (check_gap)
      for (int i = 1; i < chg_n && i < 64; i++)
        chk(chg_t[i] - chg_t[i-1] == gap, {req, " R1 bit period"}, chg_t[i] - chg_t[i-1], gap);
  endtask

  task automatic t_length();
    do_reset();
    wr(2'd0, 8'h0F);
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h01);
    mem_byte = 8'hA5;
    en(1'b1);
    repeat (17 * 8 * 27 + 800) @(negedge clk);
    chk(fetch_cnt == 17, "R3 length 16n+1", fetch_cnt, 17);
    chk(fetch_addr[0] == 16'hC080, "R3 start address", fetch_addr[0], 'hC080);
    chk(fetch_addr[16] == 16'hC090, "R6 last address", fetch_addr[16], 'hC090);
    chk(mem_req == 1'b0, "R6 no request when done", mem_req, 0);
  endtask

  task automatic t_wrap();
    do_reset();
    wr(2'd0, 8'h0F);
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'h04);
    mem_byte = 8'h0F;
    en(1'b1);
    wait_fetches(65);
    repeat (600) @(negedge clk);
    chk(fetch_cnt == 65, "R6 65-byte count", fetch_cnt, 65);
    chk(fetch_addr[0] == 16'hFFC0, "R3 top start", fetch_addr[0], 'hFFC0);
    chk(fetch_addr[63] == 16'hFFFF, "R6 top address", fetch_addr[63], 'hFFFF);
    chk(fetch_addr[64] == 16'h8000, "R6 wrap address", fetch_addr[64], 'h8000);
  endtask

  task automatic t_loop();
    int c0;
    bit same;
    do_reset();
    wr(2'd0, 8'h4F);
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h00);
    mem_byte = 8'h33;
    en(1'b1);
    repeat (1500) @(negedge clk);
    chk(fetch_cnt >= 4, "R8 loop keeps fetching", fetch_cnt, 4);
    same = 1'b1;
    for (int i = 0; i < fetch_cnt && i < 256; i++)
      if (fetch_addr[i] != 16'hC040) same = 1'b0;
    chk(same, "R8 loop reloads start", same, 1);
    en(1'b0);
    repeat (600) @(negedge clk);
    c0 = fetch_cnt;
    repeat (600) @(negedge clk);
    chk(fetch_cnt == c0, "R7 disable stops fetches", fetch_cnt, c0);
    chk(mem_req == 1'b0, "R7 no request after disable", mem_req, 0);
  endtask

  task automatic t_irq();
    do_reset();
    wr(2'd0, 8'h8F);
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h00);
    mem_byte = 8'h01;
    en(1'b1);
    repeat (10) @(negedge clk);
    chk(irq == 1'b1, "R9 irq after last byte", irq, 1);
    repeat (400) @(negedge clk);
    chk(irq == 1'b1, "R9 irq sticky", irq, 1);
    wr(2'd0, 8'h8E);
    chk(irq == 1'b1, "R9 bit7 set keeps irq", irq, 1);
    wr(2'd0, 8'h0F);
    chk(irq == 1'b0, "R9 clear by bit7=0", irq, 0);
    do_reset();
    wr(2'd0, 8'hCF);
    wr(2'd3, 8'h00);
    en(1'b1);
    repeat (1000) @(negedge clk);
    chk(irq == 1'b0, "R8 no irq when looping", irq, 0);
  endtask

  task automatic t_reenable();
    int c0;
    do_reset();
    wr(2'd0, 8'h0F);
    wr(2'd2, 8'h02);
    wr(2'd3, 8'h01);
    mem_byte = 8'hF0;
    en(1'b1);
    wait_fetches(2);
    wr(2'd2, 8'h10);
    en(1'b1);
    wait_fetches(4);
    chk(fetch_addr[2] == 16'hC082, "R7 no reload while busy", fetch_addr[2], 'hC082);
    chk(fetch_addr[3] == 16'hC083, "R7 address continues", fetch_addr[3], 'hC083);
    en(1'b0);
    repeat (300) @(negedge clk);
    c0 = fetch_cnt;
    repeat (600) @(negedge clk);
    chk(fetch_cnt == c0, "R7 disable mid-sample", fetch_cnt, c0);
    en(1'b1);
    repeat (6) @(negedge clk);
    chk(fetch_cnt == c0 + 1, "R7 enable reloads when empty", fetch_cnt, c0 + 1);
    chk(fetch_addr[c0] == 16'hC400, "R7 reload uses new start", fetch_addr[c0], 'hC400);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_direct();
    t_play("up", 64, 8'hFF, 8'h0F, 1'b1);
    t_play("clamp-high", 124, 8'hFF, 8'h0F, 1'b0);
    t_play("clamp-low", 3, 8'h00, 8'h0F, 1'b0);
    t_play("mixed", 40, 8'h55, 8'h0F, 1'b0);
    t_play("lsb-first", 1, 8'hA6, 8'h0F, 1'b0);
    t_play("R1 rate14 bits54 set", 20, 8'hFF, 8'h3E, 1'b1);
    t_play("R1 rate12", 20, 8'hFF, 8'h0C, 1'b1);
    t_length();
    t_wrap();
    t_loop();
    t_irq();
    t_reenable();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule